// File: doc/BRIEF.md
# Peak-Hold Cell Derandomizer Controller

This block steers a small bank of analogue peak-capture cells that all sit on one self-triggered detector channel, and it feeds the captured amplitudes one by one to a single shared converter. A front-end discriminator marks each new pulse with a one-cycle strobe. The controller hands that pulse to the lowest-numbered idle cell and sets that cell to track. The cell stays there until it reports that it has found the peak. It then holds the value and waits in line. When the converter is free, the oldest waiting cell is switched to drive the shared output line and a conversion is started. When the converter reports completion, the cell gets a one-cycle clear pulse and returns to the idle pool.

Only cells that captured a real pulse ever reach the converter, so baseline is never digitised. The bank absorbs bursts of closely spaced pulses, which lets the converter be sized for the mean event rate rather than the peak rate. A pulse that arrives while every cell is occupied is lost, and a saturating counter records it. The cell index queue is exactly as deep as the bank, so it can never overflow.

Top module: `pkdh_derand_ctrl`

## Requirements
- R1: A `pulse_in` strobe in a cycle where at least one cell is idle claims the idle cell with the lowest index. That cell's `cell_track` bit goes high in the next cycle, and only one cell is claimed per strobe.
- R2: A `pulse_in` strobe in a cycle where no cell is idle changes no cell. `ovf_count` rises by one in the next cycle and saturates at its all-ones value.
- R3: `peak_found[i]` in a cycle where cell i is tracking lowers `cell_track[i]` in the next cycle, and the cell then holds. `peak_found[i]` for a cell that is not tracking has no effect.
- R4: Held cells are converted strictly in the order in which their pulses arrived, and only one at a time. When the oldest occupied cell is holding and no conversion is running, `adc_start` is high for exactly one cycle in the next cycle. That cell's `cell_read` bit rises in the same cycle and stays high until the conversion ends.
- R5: If the oldest occupied cell is still tracking, no conversion starts, even when younger cells are already holding.
- R6: `adc_done` during a conversion produces, in the next cycle, a one-cycle `cell_clear` pulse on the cell being read, drops its `cell_read` bit and makes the cell idle. `adc_done` with no conversion running is ignored.
- R7: `busy` is high exactly in the cycles where no cell is idle.
- R8: A synchronous `rst` makes every cell idle, empties the queue, ends any conversion, clears `ovf_count` and holds all outputs low.
- R9: A cell freed by a completion can be claimed by a strobe in the cycle its clear pulse is shown. The next conversion can start at the earliest in the cycle after that clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | One-cycle strobe: new pulse detected |
| peak_found | input | N | Per cell: peak of the tracked pulse reached |
| adc_done | input | 1 | Converter finished the running conversion |
| cell_track | output | N | Per cell: write (tracking) phase enabled |
| cell_read | output | N | Per cell: read phase, cell drives the shared line |
| cell_clear | output | N | Per cell: one-cycle discharge pulse |
| adc_start | output | 1 | One-cycle conversion start |
| busy | output | 1 | All cells occupied |
| ovf_count | output | OVF_W | Saturating count of lost pulses |

## Verification
Each result is registered and is due one rising edge after its cause. A strobe shows up as a raised `cell_track` bit or a bumped `ovf_count` one edge later. A peak lowers `cell_track` one edge later. A holding head cell with the converter idle shows up as `adc_start` and `cell_read` one edge later. A completion shows up as `cell_clear` one edge later. `busy` follows the cell states with no extra register. The bench drives every input on the falling edge and advances its own reference model once per rising edge. It compares all outputs 1 ns after that edge, so every check lands in the cycle where the requirement says the result must appear. Random traffic with three densities is mixed with directed cases for out-of-order peaks, a full bank with counter saturation, and reuse of a cell right after its clear pulse.

// File: rtl/pkdh_pkg.sv
package pkdh_pkg;

  // Life cycle of one peak-capture cell.
  typedef enum logic [1:0] {
    CELL_IDLE  = 2'd0,
    CELL_TRACK = 2'd1,
    CELL_HOLD  = 2'd2,
    CELL_READ  = 2'd3
  } cell_st_e;

endpackage

// File: rtl/pkdh_cell.sv
module pkdh_cell
  import pkdh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     claim_i,
  input  logic     peak_i,
  input  logic     read_go_i,
  input  logic     done_i,
  output cell_st_e st_o,
  output logic     clear_o
);

  cell_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CELL_IDLE:  if (claim_i)   st_d = CELL_TRACK;
      CELL_TRACK: if (peak_i)    st_d = CELL_HOLD;
      CELL_HOLD:  if (read_go_i) st_d = CELL_READ;
      CELL_READ:  if (done_i)    st_d = CELL_IDLE;
      default:                   st_d = CELL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CELL_IDLE;
      clear_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      clear_o <= (st_q == CELL_READ) && done_i;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/pkdh_alloc.sv
module pkdh_alloc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  idle_i,
  input  logic          req_i,
  output logic [N-1:0]  grant_oh_o,
  output logic [IW-1:0] grant_idx_o,
  output logic          any_idle_o
);

  // Index of the lowest set bit; 0 when none.
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  assign any_idle_o  = |idle_i;
  assign grant_idx_o = lowest_set(idle_i);

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant_oh_o[g] = req_i && any_idle_o && (grant_idx_o == IW'(g));
  end

endmodule

// File: rtl/pkdh_idx_fifo.sv
module pkdh_idx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= din_i;
        wr_ptr      <= ptr_next(wr_ptr);
      end
      if (pop_i) rd_ptr <= ptr_next(rd_ptr);
      if (push_i && !pop_i)      cnt <= cnt + CW'(1);
      else if (pop_i && !push_i) cnt <= cnt - CW'(1);
    end
  end

  assign head_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign count_o = cnt;

endmodule

// File: rtl/pkdh_derand_ctrl.sv
module pkdh_derand_ctrl
  import pkdh_pkg::*;
#(
  parameter int N     = 4,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic [N-1:0]     peak_found,
  input  logic             adc_done,
  output logic [N-1:0]     cell_track,
  output logic [N-1:0]     cell_read,
  output logic [N-1:0]     cell_clear,
  output logic             adc_start,
  output logic             busy,
  output logic [OVF_W-1:0] ovf_count
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  function automatic logic [OVF_W-1:0] sat_inc(input logic [OVF_W-1:0] v);
    return (v == '1) ? v : v + OVF_W'(1);
  endfunction

  cell_st_e      cell_st [N];
  logic [N-1:0]  idle_vec, hold_vec, grant_oh, go_vec, rel_vec;
  logic [IW-1:0] grant_idx, head_idx, cur_idx;
  logic          any_idle, q_empty, conv_busy;
  logic [CW-1:0] q_count;

  // Named internal events, visible to the checker.
  logic ev_accept, ev_drop, conv_start, conv_release, head_held;

  assign ev_accept    = pulse_in && any_idle;
  assign ev_drop      = pulse_in && !any_idle;
  assign head_held    = !q_empty && hold_vec[head_idx];
  assign conv_start   = !conv_busy && head_held;
  assign conv_release = conv_busy && adc_done;

  pkdh_alloc #(.N(N), .IW(IW)) u_alloc (
    .idle_i      (idle_vec),
    .req_i       (pulse_in),
    .grant_oh_o  (grant_oh),
    .grant_idx_o (grant_idx),
    .any_idle_o  (any_idle)
  );

  pkdh_idx_fifo #(.DEPTH(N), .W(IW), .CW(CW)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push_i  (ev_accept),
    .din_i   (grant_idx),
    .pop_i   (conv_start),
    .head_o  (head_idx),
    .empty_o (q_empty),
    .count_o (q_count)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    assign go_vec[g]  = conv_start && (head_idx == IW'(g));
    assign rel_vec[g] = conv_release && (cur_idx == IW'(g));

    pkdh_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .claim_i   (grant_oh[g]),
      .peak_i    (peak_found[g]),
      .read_go_i (go_vec[g]),
      .done_i    (rel_vec[g]),
      .st_o      (cell_st[g]),
      .clear_o   (cell_clear[g])
    );

    assign idle_vec[g]   = (cell_st[g] == CELL_IDLE);
    assign hold_vec[g]   = (cell_st[g] == CELL_HOLD);
    assign cell_track[g] = (cell_st[g] == CELL_TRACK);
    assign cell_read[g]  = (cell_st[g] == CELL_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_busy <= 1'b0;
      cur_idx   <= '0;
      adc_start <= 1'b0;
      ovf_count <= '0;
    end else begin
      adc_start <= conv_start;
      if (conv_start) begin
        conv_busy <= 1'b1;
        cur_idx   <= head_idx;
      end else if (conv_release) begin
        conv_busy <= 1'b0;
      end
      if (ev_drop) ovf_count <= sat_inc(ovf_count);
    end
  end

  assign busy = !any_idle;

endmodule

// File: rtl/pkdh_derand_chk.sv
module pkdh_derand_chk #(
  parameter int N     = 4,
  parameter int OVF_W = 8,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             pulse_in,
  input logic             adc_done,
  input logic [N-1:0]     cell_track,
  input logic [N-1:0]     cell_read,
  input logic [N-1:0]     cell_clear,
  input logic             adc_start,
  input logic             busy,
  input logic [OVF_W-1:0] ovf_count,
  input logic [CW-1:0]    q_count,
  input logic             conv_busy
);

  p_new_track_needs_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (|(cell_track & ~$past(cell_track))) |-> $past(pulse_in));

  p_drop_counts_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && pulse_in && (ovf_count != '1)) |=> (ovf_count == $past(ovf_count) + OVF_W'(1)));

  p_single_reader_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cell_read));

  p_start_has_reader_r4: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> ($countones(cell_read) == 1));

  p_queue_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(q_count) <= N);

  p_clear_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    (|cell_clear) |-> ($past(adc_done) && $onehot(cell_clear) && ((cell_clear & cell_read) == '0)));

  p_busy_matches_occupancy_r7: assert property (@(posedge clk) disable iff (rst)
    busy == ((int'(q_count) + int'(conv_busy)) == N));

  p_start_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

endmodule

bind pkdh_derand_ctrl pkdh_derand_chk #(.N(N), .OVF_W(OVF_W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pulse_in   (pulse_in),
  .adc_done   (adc_done),
  .cell_track (cell_track),
  .cell_read  (cell_read),
  .cell_clear (cell_clear),
  .adc_start  (adc_start),
  .busy       (busy),
  .ovf_count  (ovf_count),
  .q_count    (q_count),
  .conv_busy  (conv_busy)
);

// File: tb/tb_pkdh_derand_ctrl.sv
`timescale 1ns/1ps
module tb_pkdh_derand_ctrl;

  localparam int N       = 4;
  localparam int OVF_W   = 8;
  localparam int OVF_MAX = (1 << OVF_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pulse_in = 1'b0;
  logic [N-1:0]     peak_found = '0;
  logic             adc_done = 1'b0;
  logic [N-1:0]     cell_track, cell_read, cell_clear;
  logic             adc_start, busy;
  logic [OVF_W-1:0] ovf_count;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  pkdh_derand_ctrl #(.N(N), .OVF_W(OVF_W)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .peak_found(peak_found),
    .adc_done(adc_done), .cell_track(cell_track), .cell_read(cell_read),
    .cell_clear(cell_clear), .adc_start(adc_start), .busy(busy),
    .ovf_count(ovf_count)
  );

  // Reference model: 0 idle, 1 tracking, 2 holding, 3 reading.
  int m_st [N];
  int m_q [$];
  bit m_conv;
  int m_cur;
  int m_ovf;
  bit [N-1:0] m_clr;
  bit m_start;

  function automatic bit [N-1:0] st_vec(input int code);
    bit [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[i] = (m_st[i] == code);
    return v;
  endfunction

  function automatic bit all_taken();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp, input string ctx);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0h exp=%0h (%s) t=%0t", req, what, act, exp, ctx, $time);
    end
  endtask

  task automatic compare_all(input string ctx);
    vectors++;
    chk("R1", "cell_track", 32'(cell_track), 32'(st_vec(1)), ctx);
    chk("R4", "cell_read",  32'(cell_read),  32'(st_vec(3)), ctx);
    chk("R6", "cell_clear", 32'(cell_clear), 32'(m_clr), ctx);
    chk("R4", "adc_start",  32'(adc_start),  32'(m_start), ctx);
    chk("R7", "busy",       32'(busy),       32'(all_taken()), ctx);
    chk("R2", "ovf_count",  32'(ovf_count),  32'(m_ovf), ctx);
  endtask

  task automatic do_reset(input string ctx);
    @(negedge clk);
    rst = 1'b1; pulse_in = 1'b0; peak_found = '0; adc_done = 1'b0;
    for (int i = 0; i < N; i++) m_st[i] = 0;
    m_q.delete(); m_conv = 0; m_cur = 0; m_ovf = 0; m_clr = '0; m_start = 0;
    @(posedge clk); #1;
    compare_all(ctx);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit p, input bit [N-1:0] pk, input bit d, input string ctx);
    int nst [N];
    int nq [$];
    bit [N-1:0] eclr;
    bit estart, nconv, found;
    int ncur, novf;
    @(negedge clk);
    pulse_in = p; peak_found = pk; adc_done = d;
    nst = m_st; nq = m_q; eclr = '0; estart = 0;
    nconv = m_conv; ncur = m_cur; novf = m_ovf; found = 0;
    if (m_conv && d) begin nst[m_cur] = 0; eclr[m_cur] = 1'b1; nconv = 0; end
    if (!m_conv && m_q.size() > 0 && m_st[m_q[0]] == 2) begin
      nst[m_q[0]] = 3; estart = 1; ncur = m_q[0]; nconv = 1; void'(nq.pop_front());
    end
    for (int i = 0; i < N; i++) if (m_st[i] == 1 && pk[i]) nst[i] = 2;
    if (p) begin
      for (int i = 0; i < N; i++) begin
        if (!found && m_st[i] == 0) begin nst[i] = 1; nq.push_back(i); found = 1; end
      end
      if (!found && novf < OVF_MAX) novf++;
    end
    @(posedge clk); #1;
    m_st = nst; m_q = nq; m_clr = eclr; m_start = estart;
    m_conv = nconv; m_cur = ncur; m_ovf = novf;
    compare_all(ctx);
  endtask

  task automatic idle(input int n, input string ctx);
    for (int k = 0; k < n; k++) step(0, '0, 0, ctx);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    do_reset("R8 initial reset");

    // R3: peaks on idle cells are ignored.
    step(0, '1, 0, "R3 peak on idle cells");
    // R1: successive strobes take cells 0 then 1.
    step(1, '0, 0, "R1 first claim");
    step(1, '0, 0, "R1 second claim");
    // R5: younger cell holds first, head still tracking -> no start.
    step(0, 4'b0010, 0, "R5 younger peaks first");
    idle(3, "R5 head still tracking");
    step(0, 4'b0001, 0, "R3 head peaks");
    step(0, '0, 0, "R4 start on head");
    step(0, '0, 1, "R6 done on head");
    step(0, '0, 0, "R4 next in order");
    step(0, '0, 1, "R6 done second");
    step(0, '0, 1, "R6 done while idle ignored");

    // R2/R7: fill the bank and saturate the lost-pulse counter.
    for (int k = 0; k < N; k++) step(1, '0, 0, "R7 filling");
    for (int k = 0; k < OVF_MAX + 10; k++) step(1, '0, 0, "R2 drop and saturate");

    // R9: free one cell and reuse it during its clear pulse.
    step(0, '1, 0, "R3 all peak");
    step(0, '0, 0, "R4 start");
    step(0, '0, 1, "R9 done");
    step(1, '0, 0, "R9 reclaim during clear");
    step(0, '0, 0, "R9 next start");
    idle(2, "R9 settle");

    do_reset("R8 reset mid run");

    // Random traffic in three densities.
    for (int ph = 0; ph < 3; ph++) begin
      int pp, pd;
      pp = (ph == 0) ? 10 : (ph == 1) ? 35 : 70;
      pd = (ph == 0) ? 40 : (ph == 1) ? 20 : 8;
      for (int k = 0; k < 3000; k++) begin
        bit [N-1:0] pk;
        for (int i = 0; i < N; i++) pk[i] = ($urandom % 100) < 30;
        step(($urandom % 100) < pp, pk, ($urandom % 100) < pd, "R4 R9 random");
      end
    end

    do_reset("R8 final reset");
    idle(2, "R8 quiet after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule